// File: doc/BRIEF.md
# Isolated Memory Region Access Filter

This block sits in front of memory and judges every transaction against eight programmable protected regions. Each region holds an inclusive address window with 1 KiB resolution, an enable, a lock, and two permission masks: one for reads and one for writes, with one bit for each requesting agent class. An access that lands in an enabled region and lacks permission for its agent and direction is denied. The denial also raises a one-cycle violation pulse and a sticky system reset request.

Firmware programs the regions through a simple write port. Each write selects a region, selects a field and carries a 32-bit data word. Setting a region's lock freezes every field of that region until the next global reset. Unlocked regions can be moved, re-masked or disabled at any time. A disabled region imposes no restriction.

Top module: `imr_filter`

## Requirements
- R1: Eight independent regions exist. Region n matches an access when its enable is set and {base,10'h000} <= address <= {end,10'h3FF}, with base and end being 22-bit page numbers. Both bounds are inclusive at 1 KiB granularity.
- R2: An access that matches no enabled region is granted whatever its agent class and direction.
- R3: Agent class codes are: 0 memory flush, 1 CPU snoop, 2 CPU in management mode, 3 CPU in normal mode, 4 management unit, 5 PCIe VC0, 6 PCIe VC1. A read inside a region needs read-mask bit [class], and a write needs write-mask bit [class]. Class 7 has no mask bit, so it is denied inside any enabled region.
- R4: The snoop class (code 1) has no read permission. Read-mask bit 1 always stores 0, so a snoop read inside an enabled region is denied.
- R5: When several enabled regions match an access, the access is granted only if every matching region permits it.
- R6: A request accepted on clock edge t is answered after edge t. In that cycle exactly one of grant_o and deny_o is high, and both are low in cycles that follow no request.
- R7: Every deny comes with a one-cycle viol_o pulse in the same cycle. It also sets rst_req_o, which stays high until global reset.
- R8: Field codes are: 0 base (data[31:10]), 1 end (data[31:10]), 2 read mask (data[6:0]), 3 write mask (data[6:0]), 4 control (data[0] enable, data[1] lock). Other codes are ignored. A write takes effect for requests from the next cycle on.
- R9: After a region's lock bit is set, every write to that region is ignored until global reset. This covers its base, end, masks, enable and lock.
- R10: An unlocked region can be reprogrammed or disabled at any time. Disabling it removes all of its restrictions.
- R11: While rst is high and after it, all regions are disabled, unlocked and have zero masks. grant_o, deny_o, viol_o and rst_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | 32 | Byte address of the access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_class_i | input | 3 | Agent class code |
| cfg_we_i | input | 1 | Programming write strobe |
| cfg_idx_i | input | 3 | Region index |
| cfg_field_i | input | 3 | Field select |
| cfg_data_i | input | 32 | Programming data |
| grant_o | output | 1 | Access allowed (one cycle after request) |
| deny_o | output | 1 | Access refused (one cycle after request) |
| viol_o | output | 1 | Violation pulse |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
Region state can only be seen through decisions. A wrong bound, mask bit, enable or lock therefore shows up as a flipped grant or deny on the first request that falls into the affected window. That flip appears one cycle after the request. The bench probes addresses on both sides of each bound, uses every agent class and both directions, and places overlapping windows, so a stored fault surfaces within a few requests. A missed or spurious violation sticks in rst_req_o, so it also stays visible on every later check.

// File: rtl/imr_pkg.sv
package imr_pkg;
    localparam int NUM_REGIONS = 8;
    localparam int ADDR_W      = 32;
    localparam int GRAN_W      = 10;
    localparam int PAGE_W      = ADDR_W - GRAN_W;
    localparam int NUM_CLASSES = 7;
    localparam int CLASS_W     = 3;
    localparam int IDX_W       = $clog2(NUM_REGIONS);
    localparam int FIELD_W     = 3;
    localparam int SNOOP_CLASS = 1;

    // read mask bits that may ever be set: the snoop class cannot read
    localparam logic [NUM_CLASSES-1:0] READ_ALLOWED =
        ~(NUM_CLASSES'(1) << SNOOP_CLASS);

    typedef enum logic [FIELD_W-1:0] {
        FLD_BASE  = 3'd0,
        FLD_END   = 3'd1,
        FLD_RMASK = 3'd2,
        FLD_WMASK = 3'd3,
        FLD_CTRL  = 3'd4
    } cfg_field_e;

    typedef struct packed {
        logic [PAGE_W-1:0]      base;
        logic [PAGE_W-1:0]      last;
        logic [NUM_CLASSES-1:0] rmask;
        logic [NUM_CLASSES-1:0] wmask;
        logic                   en;
        logic                   lock;
    } region_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic               wr;
        logic [CLASS_W-1:0] cls;
    } access_t;

    function automatic logic class_bit(input logic [NUM_CLASSES-1:0] m,
                                       input logic [CLASS_W-1:0] c);
        logic r;
        r = 1'b0;
        for (int k = 0; k < NUM_CLASSES; k++)
            if (c == CLASS_W'(k)) r = m[k];
        return r;
    endfunction
endpackage

// File: rtl/imr_region.sv
module imr_region
    import imr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_i,
    input  logic [FIELD_W-1:0]  field_i,
    input  logic [ADDR_W-1:0]   data_i,
    input  access_t             acc_i,
    output logic                hit_o,
    output logic                permit_o
);
    region_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (sel_i && !st.lock) begin
            case (cfg_field_e'(field_i))
                FLD_BASE:  st.base  <= data_i[ADDR_W-1:GRAN_W];
                FLD_END:   st.last  <= data_i[ADDR_W-1:GRAN_W];
                FLD_RMASK: st.rmask <= data_i[NUM_CLASSES-1:0] & READ_ALLOWED;
                FLD_WMASK: st.wmask <= data_i[NUM_CLASSES-1:0];
                FLD_CTRL: begin
                    st.en   <= data_i[0];
                    st.lock <= data_i[1];
                end
                default: ;
            endcase
        end
    end

    logic [ADDR_W-1:0] lo_addr, hi_addr;
    assign lo_addr = {st.base, {GRAN_W{1'b0}}};
    assign hi_addr = {st.last, {GRAN_W{1'b1}}};

    always_comb begin
        hit_o    = st.en && (acc_i.addr >= lo_addr) && (acc_i.addr <= hi_addr);
        permit_o = acc_i.wr ? class_bit(st.wmask, acc_i.cls)
                            : class_bit(st.rmask, acc_i.cls);
    end
endmodule

// File: rtl/imr_combine.sv
module imr_combine
    import imr_pkg::*;
(
    input  logic [NUM_REGIONS-1:0] hit_i,
    input  logic [NUM_REGIONS-1:0] permit_i,
    output logic                   allow_o
);
    logic [NUM_REGIONS-1:0] pass;
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_pass
        assign pass[g] = !hit_i[g] || permit_i[g];
    end
    assign allow_o = &pass;
endmodule

// File: rtl/imr_filter.sv
module imr_filter
    import imr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic               req_write_i,
    input  logic [CLASS_W-1:0] req_class_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [FIELD_W-1:0] cfg_field_i,
    input  logic [ADDR_W-1:0]  cfg_data_i,
    output logic               grant_o,
    output logic               deny_o,
    output logic               viol_o,
    output logic               rst_req_o
);
    access_t                acc;
    logic [NUM_REGIONS-1:0] hit, permit;
    logic                   allow;

    assign acc = '{addr: req_addr_i, wr: req_write_i, cls: req_class_i};

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        imr_region u_region (
            .clk      (clk),
            .rst      (rst),
            .sel_i    (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
            .field_i  (cfg_field_i),
            .data_i   (cfg_data_i),
            .acc_i    (acc),
            .hit_o    (hit[g]),
            .permit_o (permit[g])
        );
    end

    imr_combine u_combine (
        .hit_i    (hit),
        .permit_i (permit),
        .allow_o  (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o   <= 1'b0;
            deny_o    <= 1'b0;
            viol_o    <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            grant_o <= req_valid_i && allow;
            deny_o  <= req_valid_i && !allow;
            viol_o  <= req_valid_i && !allow;
            if (req_valid_i && !allow) rst_req_o <= 1'b1;
        end
    end
endmodule

// File: rtl/imr_checker.sv
module imr_checker
    import imr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid_i,
    input logic [ADDR_W-1:0]  req_addr_i,
    input logic               req_write_i,
    input logic [CLASS_W-1:0] req_class_i,
    input logic               cfg_we_i,
    input logic [IDX_W-1:0]   cfg_idx_i,
    input logic [FIELD_W-1:0] cfg_field_i,
    input logic [ADDR_W-1:0]  cfg_data_i,
    input logic               grant_o,
    input logic               deny_o,
    input logic               viol_o,
    input logic               rst_req_o
);
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_o, deny_o})); // R6
    AST_ANSWER_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> (grant_o || deny_o)); // R6
    AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> !(grant_o || deny_o)); // R6
    AST_VIOL_WITH_DENY: assert property (@(posedge clk) disable iff (rst)
        viol_o == deny_o); // R7
    AST_VIOL_RAISES_RST: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> rst_req_o); // R7
    AST_RST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> rst_req_o); // R7
    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> !(grant_o || deny_o || viol_o || rst_req_o)); // R11
endmodule

bind imr_filter imr_checker u_chk (.*);

// File: tb/imr_filter_bench.sv
module imr_filter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_class = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [2:0]  cfg_field = '0;
    logic [31:0] cfg_data = '0;
    logic        grant, deny, viol, rst_req;

    always #4 clk = ~clk;

    imr_filter u_imr_filter (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_addr_i(req_addr),
        .req_write_i(req_write), .req_class_i(req_class),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
        .cfg_field_i(cfg_field), .cfg_data_i(cfg_data),
        .grant_o(grant), .deny_o(deny), .viol_o(viol), .rst_req_o(rst_req)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    logic [21:0] m_base [8];
    logic [21:0] m_last [8];
    logic [6:0]  m_rmask [8];
    logic [6:0]  m_wmask [8];
    logic        m_en [8];
    logic        m_lock [8];
    logic        m_rst;

    task automatic check(input bit ok, input string req, input logic [3:0] act,
                         input logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic exp_allow(input logic [31:0] a, input logic w,
                                       input logic [2:0] c);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (m_en[i] && a[31:10] >= m_base[i] && a[31:10] <= m_last[i]) begin
                if (c == 3'd7) ok = 1'b0;
                else if (w && !m_wmask[i][c]) ok = 1'b0;
                else if (!w && !m_rmask[i][c]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_last[i] = '0; m_rmask[i] = '0;
            m_wmask[i] = '0; m_en[i] = 0; m_lock[i] = 0;
        end
        m_rst = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 0; cfg_we = 0;
        @(negedge clk);
        @(negedge clk);
        model_clear();
        check({grant, deny, viol, rst_req} == 4'b0, "R11 reset outputs",
              {grant, deny, viol, rst_req}, 4'b0);
        rst = 1'b0;
    endtask

    task automatic cfg(input int idx, input int fld, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_field = 3'(fld); cfg_data = d;
        if (!m_lock[idx]) begin
            case (fld)
                0: m_base[idx] = d[31:10];
                1: m_last[idx] = d[31:10];
                2: m_rmask[idx] = d[6:0] & 7'h7D;
                3: m_wmask[idx] = d[6:0];
                4: begin m_en[idx] = d[0]; m_lock[idx] = d[1]; end
                default: ;
            endcase
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic access(input logic [31:0] a, input logic w, input logic [2:0] c,
                          input string req);
        logic ok;
        logic [3:0] exp, act;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = w; req_class = c;
        ok = exp_allow(a, w, c);
        if (!ok) m_rst = 1;
        exp = {ok, !ok, !ok, m_rst};
        @(negedge clk);
        req_valid = 0;
        act = {grant, deny, viol, rst_req};
        check(act == exp, req, act, exp);
    endtask

    function automatic logic [31:0] pg(input int p);
        return 32'(p) << 10;
    endfunction

    initial begin : wd
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] idle;
        void'($urandom(32'd4477));
        model_clear();
        do_reset();
        access(32'h1234_5678, 0, 3'd7, "R2 empty map grant");
        // R1 bounds of region 0: pages 0x10..0x1F
        cfg(0, 0, pg(16));
        cfg(0, 1, pg(31));
        cfg(0, 4, 32'h1);
        access(pg(16), 0, 3'd3, "R1 lower bound inside");
        access(pg(31) | 32'h3FF, 1, 3'd5, "R1 upper bound inside");
        access(pg(32), 0, 3'd3, "R1 above end outside");
        access(pg(16) - 1, 1, 3'd0, "R1 below base outside");
        // R6 idle cycle shows no answer
        @(negedge clk);
        idle = {grant, deny, viol, rst_req};
        check(idle == 4'b0001, "R6 idle no answer, R7 sticky", idle, 4'b0001);
        // R3 per class and direction
        cfg(0, 2, 32'h08);
        cfg(0, 3, 32'h20);
        access(pg(20), 0, 3'd3, "R3 read class3 allowed");
        access(pg(20), 0, 3'd2, "R3 read class2 denied");
        access(pg(20), 1, 3'd3, "R3 write class3 denied");
        access(pg(20), 1, 3'd5, "R3 write class5 allowed");
        access(pg(20), 1, 3'd7, "R3 class7 denied");
        // R4 snoop read never allowed
        cfg(0, 2, 32'h7F);
        cfg(0, 3, 32'h02);
        access(pg(20), 0, 3'd1, "R4 snoop read denied");
        access(pg(20), 1, 3'd1, "R4 snoop write allowed");
        access(pg(20), 0, 3'd6, "R3 read class6 allowed");
        // R5 overlapping region 1: pages 0x18..0x30, no read rights
        cfg(1, 0, pg(24));
        cfg(1, 1, pg(48));
        cfg(1, 4, 32'h1);
        access(pg(24), 0, 3'd3, "R5 overlap denied");
        access(pg(18), 0, 3'd3, "R5 region0 only allowed");
        access(pg(40), 0, 3'd3, "R5 region1 only denied");
        cfg(1, 5, 32'hFFFF_FFFF);
        access(pg(40), 0, 3'd3, "R8 bad field ignored");
        // R10 disable and reprogram
        cfg(1, 4, 32'h0);
        access(pg(40), 0, 3'd3, "R10 disabled region no restriction");
        cfg(1, 1, pg(26));
        cfg(1, 4, 32'h1);
        access(pg(40), 0, 3'd4, "R10 reprogrammed end");
        access(pg(25), 0, 3'd4, "R10 reprogrammed still covers");
        // R9 lock region 0
        cfg(0, 4, 32'h3);
        cfg(0, 4, 32'h0);
        cfg(0, 2, 32'h0);
        cfg(0, 0, pg(0));
        access(pg(18), 0, 3'd3, "R9 locked masks kept");
        access(pg(18), 0, 3'd7, "R9 locked enable kept");
        access(pg(8), 0, 3'd7, "R9 locked base kept");
        // R11 reset clears everything including lock
        do_reset();
        access(pg(18), 0, 3'd7, "R11 regions disabled after reset");
        cfg(0, 4, 32'h1);
        access(pg(0), 0, 3'd0, "R11 masks zero after reset");
        // random phase
        for (int it = 0; it < 600; it++) begin
            if (it == 300) do_reset();
            if ($urandom_range(0, 3) == 0) begin
                int f;
                logic [31:0] d;
                f = $urandom_range(0, 5);
                d = $urandom();
                if (f <= 1) d = pg($urandom_range(0, 63)) | 32'(d[9:0]);
                if (f == 4) d = {30'b0, ($urandom_range(0, 24) == 0), d[0]};
                cfg($urandom_range(0, 7), f, d);
            end else begin
                access(pg($urandom_range(0, 70)) | 32'($urandom_range(0, 1023)),
                       1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                       "R3 R5 random access");
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule